// File: doc/BRIEF.md
# Pushbutton Up/Down Step Controller

This block turns two active-low pushbuttons into moves of a saturating position code, for example the tap code of a digital resistor ladder. Each button is brought into the clock domain by a flop chain and then qualified by its own timer. A low level that lasts through the debounce window moves the position by one step. If the button is still held after a long start delay, the block begins autoscan. It then steps again at once and repeats at a fixed shorter period until the button is released.

All intervals are parameters counted in clock cycles, so the same RTL serves a slow scan clock or a scaled-down test clock. Pressing both buttons at once is treated as an error. The block then makes no step and stays locked until both buttons are released. Outputs are the position code, a one-cycle strobe for each change and a flag that is high during autoscan.

Top module: `btn_step_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pos` equals `RESET_POS`, and both `step_pulse` and `scan_active` are 0.
- R2: A low run on a button input that is sampled by fewer than `DEB_CYC+1` consecutive rising clock edges causes no step. This applies also when several such runs are separated by single high samples.
- R3: An `up_n` low run of `DEB_CYC+1` up to `DEB_CYC+START_CYC` consecutive samples raises `pos` by exactly 1.
- R4: `dn_n` behaves exactly as `up_n`, except that it lowers `pos` by 1.
- R5: One high sample between two qualifying low runs is enough to re-arm the button, so each run gives its own step.
- R6: Steps are counted from the first low sample of a run. A run of L consecutive low samples gives one step at sample `DEB_CYC+1` and a second at sample `DEB_CYC+1+START_CYC`. After that it gives one more step every `REP_CYC` samples. `scan_active` is high from the second step until the button is seen high.
- R7: `pos` never wraps. At `2**POS_W-1` an up step is dropped, at 0 a down step is dropped, and a dropped step raises no strobe.
- R8: While both inputs are sampled low together, no step occurs. The block stays locked, with no step and `scan_active` low, until both inputs have been sampled high; only a press after that is qualified again.
- R9: `step_pulse` is high for exactly the one cycle in which `pos` shows a new value, and `pos` changes by exactly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all intervals are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_n | input | 1 | Up button, low while pressed, asynchronous |
| dn_n | input | 1 | Down button, low while pressed, asynchronous |
| pos | output | POS_W | Current position code |
| step_pulse | output | 1 | One-cycle strobe on each change of `pos` |
| scan_active | output | 1 | High while either button is in autoscan |

## Verification
The checker takes for granted that each button level is stable around the clock edge that samples it. Under that condition a change of `pos` can be traced to a low sample of the matching input a fixed number of edges earlier, and so can `scan_active`. The bench therefore drives both inputs only on the falling clock edge and holds every level for whole cycles. It never relies on metastability behaviour. It also picks every hold length in the middle of an interval, so that the expected number of steps does not depend on the exact synchronizer latency.

// File: rtl/btn_step_pkg.sv
package btn_step_pkg;

   typedef enum logic [1:0] {
      QS_IDLE = 2'd0,
      QS_DEB  = 2'd1,
      QS_HOLD = 2'd2,
      QS_SCAN = 2'd3
   } qual_state_e;

   localparam int BTN_UP = 0;
   localparam int BTN_DN = 1;
   localparam int BTN_N  = 2;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_n,
   output logic press
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= din_n;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din_n};
         end
      end
   endgenerate

   assign press = ~chain[STAGES-1];
endmodule

// File: rtl/btn_qual.sv
module btn_qual
   import btn_step_pkg::*;
#(
   parameter int DEB_CYC   = 8,
   parameter int START_CYC = 60,
   parameter int REP_CYC   = 20,
   parameter int CW        = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic press,
   output logic req,
   output logic scanning
);
   localparam logic [CW-1:0] DEB_LAST   = CW'(DEB_CYC - 1);
   localparam logic [CW-1:0] START_LAST = CW'(START_CYC - 1);
   localparam logic [CW-1:0] REP_LAST   = CW'(REP_CYC - 1);

   qual_state_e    state;
   logic [CW-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= QS_IDLE;
         cnt   <= '0;
         req   <= 1'b0;
      end else begin
         req <= 1'b0;
         if (!press) begin
            state <= QS_IDLE;
            cnt   <= '0;
         end else begin
            unique case (state)
               QS_IDLE: begin
                  state <= QS_DEB;
                  cnt   <= '0;
               end
               QS_DEB: begin
                  if (cnt == DEB_LAST) begin
                     req   <= 1'b1;
                     state <= QS_HOLD;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               QS_HOLD: begin
                  if (cnt == START_LAST) begin
                     req   <= 1'b1;
                     state <= QS_SCAN;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               QS_SCAN: begin
                  if (cnt == REP_LAST) begin
                     req <= 1'b1;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  state <= QS_IDLE;
                  cnt   <= '0;
               end
            endcase
         end
      end
   end

   assign scanning = (state == QS_SCAN);
endmodule

// File: rtl/pos_sat.sv
module pos_sat #(
   parameter int POS_W     = 5,
   parameter int RESET_POS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [POS_W-1:0] pos,
   output logic             step
);
   localparam logic [POS_W-1:0] POS_MAX  = '1;
   localparam logic [POS_W-1:0] POS_INIT = POS_W'(RESET_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos  <= POS_INIT;
         step <= 1'b0;
      end else begin
         step <= 1'b0;
         if (inc && !dec && pos != POS_MAX) begin
            pos  <= pos + 1'b1;
            step <= 1'b1;
         end else if (dec && !inc && pos != '0) begin
            pos  <= pos - 1'b1;
            step <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/btn_step_ctrl.sv
module btn_step_ctrl
   import btn_step_pkg::*;
#(
   parameter int POS_W       = 5,
   parameter int RESET_POS   = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYC     = 550000,
   parameter int START_CYC   = 40000000,
   parameter int REP_CYC     = 12500000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_n,
   input  logic             dn_n,
   output logic [POS_W-1:0] pos,
   output logic             step_pulse,
   output logic             scan_active
);
   localparam int CW = $clog2(max3(DEB_CYC, START_CYC, REP_CYC) + 1);

   generate
      if (POS_W < 1)                         begin : g_bad_w   $error("POS_W must be at least 1"); end
      if (RESET_POS < 0 || RESET_POS >= (1 << POS_W))
                                             begin : g_bad_rp  $error("RESET_POS out of range"); end
      if (SYNC_STAGES < 1)                   begin : g_bad_s   $error("SYNC_STAGES must be at least 1"); end
      if (DEB_CYC < 1)                       begin : g_bad_d   $error("DEB_CYC must be at least 1"); end
      if (START_CYC < 2 || REP_CYC < 2)      begin : g_bad_t   $error("START_CYC and REP_CYC must be at least 2"); end
   endgenerate

   logic [BTN_N-1:0] press_s;
   logic [BTN_N-1:0] press_q;
   logic [BTN_N-1:0] req;
   logic [BTN_N-1:0] scan;
   logic             both;
   logic             lock;

   assign both = &press_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lock <= 1'b0;
      else if (both)      lock <= 1'b1;
      else if (~|press_s) lock <= 1'b0;
   end

   generate
      for (genvar b = 0; b < BTN_N; b++) begin : g_btn
         logic raw_n;
         if (b == BTN_UP) begin : g_up
            assign raw_n = up_n;
         end else begin : g_dn
            assign raw_n = dn_n;
         end

         btn_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din_n (raw_n),
            .press (press_s[b])
         );

         assign press_q[b] = press_s[b] & ~both & ~lock;

         btn_qual #(
            .DEB_CYC   (DEB_CYC),
            .START_CYC (START_CYC),
            .REP_CYC   (REP_CYC),
            .CW        (CW)
         ) i_qual (
            .clk      (clk),
            .rst_n    (rst_n),
            .press    (press_q[b]),
            .req      (req[b]),
            .scanning (scan[b])
         );
      end
   endgenerate

   pos_sat #(.POS_W(POS_W), .RESET_POS(RESET_POS)) i_pos (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (req[BTN_UP]),
      .dec   (req[BTN_DN]),
      .pos   (pos),
      .step  (step_pulse)
   );

   assign scan_active = |scan;
endmodule

// File: rtl/btn_step_checker.sv
module btn_step_checker #(
   parameter int POS_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             up_n,
   input logic             dn_n,
   input logic [POS_W-1:0] pos,
   input logic             step_pulse,
   input logic             scan_active
);
   generate
      if (SYNC_STAGES == 2) begin : g_lat
         // R3: a rise in pos traces back to a low up sample four edges earlier
         a_r3_up_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
            (pos > $past(pos)) |-> ($past(up_n, 4) == 1'b0));
         // R4: a fall in pos traces back to a low down sample four edges earlier
         a_r4_dn_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
            (pos < $past(pos)) |-> ($past(dn_n, 4) == 1'b0));
         // R6: autoscan only while a button was seen low
         a_r6_scan_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
            scan_active |-> ($past(up_n, 3) == 1'b0 || $past(dn_n, 3) == 1'b0));
      end
   endgenerate

   // R7: moves are single steps, so no wrap between the ends
   a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (pos != $past(pos)) |-> (pos == $past(pos) + 1 || pos == $past(pos) - 1));
   // R9: strobe marks exactly the cycles with a new position
   a_r9_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      step_pulse |-> (pos != $past(pos)));
   a_r9_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (pos != $past(pos)) |-> step_pulse);
   a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      step_pulse |=> !step_pulse);
endmodule

bind btn_step_ctrl btn_step_checker #(.POS_W(POS_W), .SYNC_STAGES(SYNC_STAGES)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .up_n        (up_n),
   .dn_n        (dn_n),
   .pos         (pos),
   .step_pulse  (step_pulse),
   .scan_active (scan_active)
);

// File: tb/test_btn_step_ctrl.sv
module test_btn_step_ctrl;
   localparam int W     = 5;
   localparam int RPOS  = 16;
   localparam int DEB   = 8;
   localparam int START = 60;
   localparam int REP   = 20;
   localparam int SETTLE = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         up_n = 1'b1;
   logic         dn_n = 1'b1;
   logic [W-1:0] pos;
   logic         step_pulse;
   logic         scan_active;

   int checks = 0;
   int fails  = 0;
   int strobes = 0;
   bit done = 0;

   always #10 clk = ~clk;

   btn_step_ctrl #(
      .POS_W(W), .RESET_POS(RPOS), .SYNC_STAGES(2),
      .DEB_CYC(DEB), .START_CYC(START), .REP_CYC(REP)
   ) i_btn_step_ctrl (
      .clk(clk), .rst_n(rst_n), .up_n(up_n), .dn_n(dn_n),
      .pos(pos), .step_pulse(step_pulse), .scan_active(scan_active)
   );

   always @(negedge clk) if (rst_n && step_pulse) strobes++;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic hold(input bit up, input int n);
      @(negedge clk);
      if (up) up_n = 1'b0; else dn_n = 1'b0;
      repeat (n) @(negedge clk);
      up_n = 1'b1; dn_n = 1'b1;
      repeat (SETTLE) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 pos in reset", pos, RPOS);
      check("R1 strobe in reset", step_pulse, 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1 pos after reset", pos, RPOS);
      check("R1 scan after reset", scan_active, 0);
   endtask

   task automatic t_bounce();
      int p0 = pos, s0 = strobes;
      hold(1, DEB - 4);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); up_n = 1'b0;
         repeat (DEB) @(negedge clk);
         up_n = 1'b1;
      end
      repeat (SETTLE) @(negedge clk);
      check("R2 bounce leaves pos", pos, p0);
      check("R2 bounce gives no strobe", strobes - s0, 0);
   endtask

   task automatic t_single();
      int p0 = pos, s0 = strobes;
      hold(1, DEB + 12);
      check("R3 up press one step", pos, p0 + 1);
      check("R9 one strobe for up", strobes - s0, 1);
      hold(0, DEB + 12);
      check("R4 down press one step", pos, p0);
      check("R9 two strobes total", strobes - s0, 2);
   endtask

   task automatic t_autoscan();
      int p0 = pos, s0 = strobes;
      @(negedge clk); up_n = 1'b0;
      repeat (100) @(negedge clk);
      check("R6 scan flag while held", scan_active, 1);
      repeat (DEB + 1 + START + 2 * REP + REP / 2 - 100) @(negedge clk);
      up_n = 1'b1;
      repeat (SETTLE) @(negedge clk);
      check("R6 four steps in autoscan", pos, p0 + 4);
      check("R9 four strobes in autoscan", strobes - s0, 4);
      check("R6 scan flag after release", scan_active, 0);
   endtask

   task automatic t_saturate();
      int s0 = strobes, p0 = pos;
      hold(1, DEB + 1 + START + 38 * REP + REP / 2);
      check("R7 top end holds", pos, (1 << W) - 1);
      check("R7 no strobe past top", strobes - s0, ((1 << W) - 1) - p0);
      s0 = strobes;
      hold(0, DEB + 1 + START + 38 * REP + REP / 2);
      check("R7 bottom end holds", pos, 0);
      check("R7 no strobe past bottom", strobes - s0, (1 << W) - 1);
   endtask

   task automatic t_rearm();
      int p0 = pos;
      @(negedge clk); up_n = 1'b0;
      repeat (DEB + 12) @(negedge clk);
      up_n = 1'b1;
      @(negedge clk); up_n = 1'b0;
      repeat (DEB + 12) @(negedge clk);
      up_n = 1'b1;
      repeat (SETTLE) @(negedge clk);
      check("R5 one high sample re-arms", pos, p0 + 2);
   endtask

   task automatic t_both();
      int p0 = pos, s0 = strobes;
      @(negedge clk); up_n = 1'b0; dn_n = 1'b0;
      repeat (DEB + START + 3 * REP) @(negedge clk);
      check("R8 both held no scan", scan_active, 0);
      up_n = 1'b1;
      repeat (DEB + START + 3 * REP) @(negedge clk);
      check("R8 lock holds with down alone", scan_active, 0);
      dn_n = 1'b1;
      repeat (SETTLE) @(negedge clk);
      check("R8 both pressed no step", pos, p0);
      check("R8 no strobe while locked", strobes - s0, 0);
      hold(0, DEB + 12);
      check("R8 press after release qualifies", pos, p0 - 1);
   endtask

   initial begin
      t_reset();
      t_bounce();
      t_single();
      t_autoscan();
      t_saturate();
      t_rearm();
      t_both();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule